// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block turns a fast system clock into the serial clock of an I2C bus master. A programmable prescaler first divides the system clock into a slower module tick. Two phase counters then set how long SCL stays low and how long it stays high, both counted in module ticks. Each phase length is the programmed divider value plus a small fixed offset. That offset is chosen by the prescaler setting: 7 when the prescaler value is 0, 6 when it is 1, and 5 for any larger value.

The configuration inputs are loaded only while the module-enable input is low. They are captured into internal registers on the clock edge where enable first reads high. While the block is enabled, changes on those inputs are ignored. Releasing enable holds every counter cleared and puts SCL into its released (high) level. The internal clock reaches the SCL output only while the master-mode flag is set. A one-cycle strobe marks each falling edge of the generated clock, so a data shifter can align to it. Clock stretching, arbitration, the data path and START/STOP generation belong to other blocks.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, and from the cycle after mod_en is sampled low, scl_o is 1 and fall_stb is 0.
- R2: On the clock edge where mod_en is sampled 1 after having been 0 (or after reset), the configuration is captured. In the next cycle the generated clock is low, which is the start of a low phase, and fall_stb is 1.
- R3: Each low phase lasts exactly (low_in + d) * (psc_in + 1) clock cycles, using the captured values.
- R4: Each high phase lasts exactly (high_in + d) * (psc_in + 1) clock cycles, using the captured values.
- R5: The offset d is 7 for a captured psc_in of 0, 6 for a captured psc_in of 1, and 5 for a captured psc_in from 2 to 255.
- R6: Changes to psc_in, low_in and high_in while mod_en stays 1 have no effect on the phase lengths.
- R7: While master_mode was 0 on the previous clock edge, scl_o is 1. The internal clock keeps running, and fall_stb keeps marking its falling edges.
- R8: fall_stb is high for exactly one cycle at each falling edge of the generated clock and is 0 in every other cycle.
- R9: low_in or high_in equal to 0 is legal. That phase then lasts d * (psc_in + 1) cycles, including the case psc_in = 255.
- R10: Dropping mod_en in the middle of a phase releases scl_o high in the next cycle. A later enable starts again with a fresh low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; a 0-to-1 change captures the configuration |
| master_mode | input | 1 | When 1, the generated clock is driven on scl_o |
| psc_in | input | 8 | Prescaler value; the tick period is psc_in + 1 clocks |
| low_in | input | 16 | Low-phase divider value |
| high_in | input | 16 | High-phase divider value |
| scl_o | output | 1 | SCL drive level (1 = released) |
| fall_stb | output | 1 | One-cycle strobe at each falling edge of the generated clock |

## Verification
Two events can land on the same cycle. A phase boundary can coincide with a drop of mod_en, and the capture edge of enable can coincide with the configuration inputs changing on the very next cycle. The bench provokes the first by removing enable right after a falling-edge strobe, and also in the middle of a high phase. It provokes the second by rewriting psc_in, low_in and high_in one cycle after capture and then measuring the phase lengths. A behavioural cycle-count model runs alongside the design and is compared on every clock. The judgement is that disable always wins, with scl_o released and no strobe on the next cycle, and that the phases keep the lengths computed from the values present at the capture edge.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int PSC_W = 8;
  localparam int DIV_W = 16;
  localparam int OFS_W = 4;

  // fixed phase offset selected by the prescaler value
  function automatic logic [OFS_W-1:0] phase_offset(input logic [PSC_W-1:0] p);
    if (p == '0)      return OFS_W'(7);
    else if (p == 1)  return OFS_W'(6);
    else              return OFS_W'(5);
  endfunction
endpackage

// File: rtl/scl_cfg.sv
module scl_cfg
  import scl_pkg::*;
#(
  parameter int PW = PSC_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mod_en,
  input  logic [PW-1:0] psc_in,
  input  logic [DW-1:0] low_in,
  input  logic [DW-1:0] high_in,
  output logic          start,
  output logic          run,
  output logic [PW-1:0] psc_q,
  output logic [DW:0]   low_len,
  output logic [DW:0]   high_len
);
  localparam int LW = DW + 1;

  logic en_q;
  logic [OFS_W-1:0] ofs;

  assign start = mod_en & ~en_q;
  assign ofs   = phase_offset(PW'(psc_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      run      <= 1'b0;
      psc_q    <= '0;
      low_len  <= '0;
      high_len <= '0;
    end else begin
      en_q <= mod_en;
      if (!mod_en) begin
        run <= 1'b0;
      end else if (start) begin
        run      <= 1'b1;
        psc_q    <= psc_in;
        low_len  <= {1'b0, low_in}  + LW'(ofs);
        high_len <= {1'b0, high_in} + LW'(ofs);
      end
    end
  end

  // R6: latched configuration does not move while enabled
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (run && mod_en) |=> ($stable(psc_q) && $stable(low_len) && $stable(high_len)));

  // R5: every latched length carries at least the smallest offset
  assert_len_offset_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (low_len >= LW'(5) && high_len >= LW'(5)));
endmodule

// File: rtl/scl_presc.sv
module scl_presc #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          start,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc;

  assign tick = run && (pc == div);

  always_ff @(posedge clk) begin
    if (rst || !run || start) pc <= '0;
    else if (tick)            pc <= '0;
    else                      pc <= pc + 1'b1;
  end

  // R3: ticks are spaced by div+1 clocks, so two in a row only when div is 0
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && !start) |=> !tick);
endmodule

// File: rtl/scl_phase.sv
module scl_phase #(
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mod_en,
  input  logic          start,
  input  logic          tick,
  input  logic [LW-1:0] low_len,
  input  logic [LW-1:0] high_len,
  output logic          scl_q,
  output logic          fall_stb
);
  logic [LW-1:0] cnt;
  logic [LW-1:0] cur_len;
  logic          last;

  assign cur_len = scl_q ? high_len : low_len;
  assign last    = (cnt == cur_len - LW'(1));

  always_ff @(posedge clk) begin
    if (rst || !mod_en) begin
      scl_q    <= 1'b1;
      cnt      <= '0;
      fall_stb <= 1'b0;
    end else if (start) begin
      scl_q    <= 1'b0;
      cnt      <= '0;
      fall_stb <= 1'b1;
    end else begin
      fall_stb <= 1'b0;
      if (tick) begin
        if (last) begin
          cnt      <= '0;
          scl_q    <= ~scl_q;
          fall_stb <= scl_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (scl_q && !fall_stb));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (!scl_q && fall_stb));

  assert_strobe_low_R8: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> !scl_q);

  assert_fall_marked_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_q) |-> fall_stb);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !start && !$past(start)) |-> (cnt < cur_len));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_pkg::*;
#(
  parameter int PW = PSC_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mod_en,
  input  logic          master_mode,
  input  logic [PW-1:0] psc_in,
  input  logic [DW-1:0] low_in,
  input  logic [DW-1:0] high_in,
  output logic          scl_o,
  output logic          fall_stb
);
  localparam int LW = DW + 1;

  logic          start, run, tick, scl_q, master_q;
  logic [PW-1:0] psc_q;
  logic [LW-1:0] low_len, high_len;

  scl_cfg #(.PW(PW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .mod_en(mod_en),
    .psc_in(psc_in), .low_in(low_in), .high_in(high_in),
    .start(start), .run(run), .psc_q(psc_q),
    .low_len(low_len), .high_len(high_len)
  );

  scl_presc #(.PW(PW)) u_presc (
    .clk(clk), .rst(rst), .run(run), .start(start),
    .div(psc_q), .tick(tick)
  );

  scl_phase #(.LW(LW)) u_phase (
    .clk(clk), .rst(rst), .mod_en(mod_en), .start(start), .tick(tick),
    .low_len(low_len), .high_len(high_len),
    .scl_q(scl_q), .fall_stb(fall_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) master_q <= 1'b0;
    else     master_q <= master_mode;
  end

  assign scl_o = scl_q | ~master_q;

  assert_master_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> scl_o);

  assert_disable_release_R10: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (scl_o && !fall_stb));
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_en = 1'b0;
  logic master_mode = 1'b0;
  logic [7:0]  psc_in = '0;
  logic [15:0] low_in = '0;
  logic [15:0] high_in = '0;
  wire scl_o, fall_stb;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  scl_clkgen u0 (
    .clk(clk), .rst(rst), .mod_en(mod_en), .master_mode(master_mode),
    .psc_in(psc_in), .low_in(low_in), .high_in(high_in),
    .scl_o(scl_o), .fall_stb(fall_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: counts clocks in the current phase
  bit m_en_q = 0, m_run = 0, m_scl = 1, m_stb = 0, m_master = 0;
  int m_cnt = 0, m_p = 0, m_l = 0, m_h = 0;

  function automatic int dofs(input int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en_q = 0; m_run = 0; m_scl = 1; m_stb = 0; m_master = 0; m_cnt = 0;
    end else begin
      m_stb = 0;
      if (!mod_en) begin
        m_run = 0; m_scl = 1;
      end else if (!m_en_q) begin
        m_p = int'(psc_in); m_l = int'(low_in); m_h = int'(high_in);
        m_run = 1; m_scl = 0; m_stb = 1; m_cnt = 0;
      end else if (m_run) begin
        m_cnt++;
        if (m_cnt == ((m_scl ? m_h : m_l) + dofs(m_p)) * (m_p + 1)) begin
          m_scl = !m_scl; m_cnt = 0; m_stb = !m_scl;
        end
      end
      m_en_q = mod_en;
      m_master = master_mode;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(scl_o === (m_scl | !m_master), "R3/R4 model scl_o", int'(scl_o), int'(m_scl | !m_master));
      check(fall_stb === m_stb, "R8 model fall_stb", int'(fall_stb), int'(m_stb));
    end
  end

  task automatic enable(input int p, input int l, input int h);
    @(negedge clk);
    psc_in = 8'(p); low_in = 16'(l); high_in = 16'(h); mod_en = 1'b1;
  endtask

  task automatic disable_mod();
    @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    check(scl_o === 1'b1, "R10 released after disable", int'(scl_o), 1);
    check(fall_stb === 1'b0, "R1 no strobe when disabled", int'(fall_stb), 0);
  endtask

  // wait for strobe, then time one low and one high phase
  task automatic measure(input int exp_lo, input int exp_hi, input string tag);
    int lo = 0, hi = 0;
    do @(negedge clk); while (fall_stb !== 1'b1);
    while (scl_o === 1'b0) begin lo++; @(negedge clk); end
    while (scl_o === 1'b1) begin hi++; @(negedge clk); end
    check(lo == exp_lo, {tag, " low length"}, lo, exp_lo);
    check(hi == exp_hi, {tag, " high length"}, hi, exp_hi);
    check(fall_stb === 1'b1, "R8 strobe at next fall", int'(fall_stb), 1);
  endtask

  initial begin
    #(4 * 190000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(scl_o === 1'b1, "R1 reset scl_o", int'(scl_o), 1);
    check(fall_stb === 1'b0, "R1 reset fall_stb", int'(fall_stb), 0);
    master_mode = 1'b1;

    // d = 7
    enable(0, 3, 2);
    @(negedge clk);
    check(scl_o === 1'b0 && fall_stb === 1'b1, "R2 first phase low", int'(scl_o), 0);
    measure(10, 9, "R5 d7 R3 R4");
    disable_mod();

    // d = 6
    enable(1, 4, 1);
    measure(20, 14, "R5 d6");
    disable_mod();

    // d = 5, then inputs rewritten right after capture
    enable(3, 2, 5);
    @(negedge clk);
    psc_in = 8'd0; low_in = 16'd40; high_in = 16'd1;
    measure(28, 40, "R6 ignored writes d5");
    measure(28, 40, "R6 second period");
    disable_mod();

    // zero dividers
    enable(0, 0, 0);
    measure(7, 7, "R9 zero dividers");
    disable_mod();
    enable(255, 0, 0);
    measure(1280, 1280, "R9 max prescaler");
    disable_mod();

    // master gating while running
    enable(2, 1, 1);
    @(negedge clk);
    master_mode = 1'b0;
    repeat (60) begin
      @(negedge clk);
      check(scl_o === 1'b1, "R7 slave released", int'(scl_o), 1);
    end
    master_mode = 1'b1;
    repeat (30) @(negedge clk);

    // disable right on a strobe cycle, then mid-high phase
    do @(negedge clk); while (fall_stb !== 1'b1);
    mod_en = 1'b0;
    @(negedge clk);
    check(scl_o === 1'b1, "R10 disable at strobe", int'(scl_o), 1);
    enable(1, 6, 6);
    @(negedge clk);
    check(scl_o === 1'b0 && fall_stb === 1'b1, "R2 restart low", int'(scl_o), 0);
    do @(negedge clk); while (scl_o !== 1'b1);
    repeat (5) @(negedge clk);
    disable_mod();
    enable(1, 6, 6);
    measure(24, 24, "R10 fresh after re-enable");
    disable_mod();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule